// File: doc/BRIEF.md
# DMA Channel Service Engine

This block sequences transfers for two four-channel DMA controllers, eight channels in all. Every cycle it spends in its scanning state, it looks over all channels and chooses one that has a pending request, a clear mask bit, a ready device and an enabled controller. It then offers one memory beat for that channel. A beat is one transferred unit, and its physical address is built from the channel's page, base address and progress count.

Controller 0 moves 8-bit units and controller 1 moves 16-bit units. Each channel's base address and transfer length are therefore scaled by its controller's index, which serves as the width shift. After every accepted beat the engine goes back to scanning, so a higher-priority request that arrives during a long block gets the next beat.

Request bits are set and cleared both by device hold/release pulses and by software request writes. The register file outside this block supplies the mask, mode, page, base and count contents.

The engine has two states. SCAN leads to BEAT on the transition "pick", taken when any channel is eligible. BEAT leads back to SCAN on the transition "accept", taken when `mem_rdy_i` is high. SCAN stays in SCAN on "idle" and BEAT stays in BEAT on "stall".

Top module: `dma_svc_engine`

## Requirements
- R1: A channel n is picked only when its request bit is 1, `mask_i[n]` is 0 and `dev_rdy_i[n]` is 1. A masked or not-ready pending channel raises no `mem_req_o`, and its request bit stays set.
- R2: While `ctrl_disable_i[c]` is 1, no channel of controller c (channels 4c to 4c+3) is picked.
- R3: Among eligible channels the lowest global index wins. Controller 0 channels 0..3 therefore come before controller 1 channels 4..7.
- R4: A pulse on `dreq_hold_i[n]` sets request bit n, and a pulse on `dreq_release_i[n]` clears it. A software write (`sw_req_we_i`) sets or clears the bit of channel `sw_req_ch_i` according to `sw_req_set_i`. When a set and a clear meet in one cycle, the set wins. `req_o` shows the request bits.
- R5: A channel's block length in beats is (base count + 1) shifted left by its controller index (0 or 1).
- R6: With `mode_dec_i[n]` at 0, the beat address is page×65536 + (base address << controller index) + progress.
- R7: With `mode_dec_i[n]` at 1, the beat address is page×65536 + (base address << controller index) − progress − 1.
- R8: `mem_req_o` stays high, with `mem_chan_o` unchanged, until `mem_rdy_i` is sampled high. Each accepted beat advances that channel's progress by one.
- R9: After every accepted beat, `mem_req_o` is low for at least one cycle while the engine rescans. The next beat goes to whichever channel then has priority.
- R10: The beat that brings progress to the block length sets `tc_o[n]`, clears request bit n and returns the progress to 0.
- R11: A pulse on `tc_clr_i[c]` clears the `tc_o` bits of controller c only. A terminal beat in the same cycle keeps its bit set.
- R12: A pulse on `chan_init_i[n]` returns channel n's progress to 0, and its address follows at once.
- R13: After reset, `req_o`, `tc_o` and `mem_req_o` are all 0.
- R14: A change to mask, disable or device-ready inputs takes effect at the next scan. A pending request that was held off is serviced once the bar is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_i | input | 8 | Per-channel mask, 1 blocks service |
| ctrl_disable_i | input | 2 | Per-controller disable |
| mode_dec_i | input | 8 | Per-channel address direction, 1 = downward |
| page_i | input | 64 | Eight 8-bit page values |
| base_addr_i | input | 128 | Eight 16-bit base addresses |
| base_cnt_i | input | 128 | Eight 16-bit base counts |
| chan_init_i | input | 8 | Pulse: zero that channel's progress |
| dreq_hold_i | input | 8 | Pulse: device asserts request |
| dreq_release_i | input | 8 | Pulse: device withdraws request |
| sw_req_we_i | input | 1 | Software request write strobe |
| sw_req_ch_i | input | 3 | Channel of the software write |
| sw_req_set_i | input | 1 | 1 sets, 0 clears the request |
| tc_clr_i | input | 2 | Pulse: clear controller's terminal bits |
| dev_rdy_i | input | 8 | Per-channel device ready |
| mem_rdy_i | input | 1 | Memory accepts the current beat |
| mem_req_o | output | 1 | Beat offered |
| mem_addr_o | output | 24 | Physical beat address |
| mem_chan_o | output | 3 | Channel of the offered beat |
| req_o | output | 8 | Request bits |
| tc_o | output | 8 | Terminal-count bits |

## Verification
The hardest cases to reach from the ports are the ones where the picker's choice changes in the middle of a block. Examples are a lower-numbered request arriving while another channel's beat is stalled, or a controller being disabled between two beats. The stimulus holds `mem_rdy_i` low to freeze a beat and changes requests, disable or init pulses while it is frozen. It then releases exactly one accept cycle and observes which channel and address the next beat carries.

// File: rtl/dma_svc_pkg.sv
package dma_svc_pkg;

    typedef enum logic [0:0] {
        ST_SCAN = 1'b0,
        ST_BEAT = 1'b1
    } svc_state_e;

endpackage

// File: rtl/dma_svc_pick.sv
module dma_svc_pick #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] elig,
    output logic         found,
    output logic [W-1:0] idx
);

    // Walk from the top down so the lowest eligible index is the last written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_svc_addr.sv
module dma_svc_addr #(
    parameter int CNTW  = 16,
    parameter int PAGEW = 8,
    parameter int SHW   = 1,
    parameter int PROGW = 18,
    localparam int ADDRW = PAGEW + CNTW
) (
    input  logic [CNTW-1:0]  base_addr,
    input  logic [CNTW-1:0]  base_cnt,
    input  logic [PAGEW-1:0] page,
    input  logic             dec,
    input  logic [SHW-1:0]   shift,
    input  logic [PROGW-1:0] prog,
    output logic [ADDRW-1:0] addr,
    output logic             last
);

    logic [ADDRW-1:0] start_w;
    logic [ADDRW-1:0] page_w;
    logic [ADDRW-1:0] prog_w;
    logic [PROGW-1:0] len_w;

    always_comb begin
        start_w = ADDRW'(base_addr) << shift;
        page_w  = {page, {CNTW{1'b0}}};
        prog_w  = ADDRW'(prog);
        len_w   = (PROGW'(base_cnt) + PROGW'(1)) << shift;
        if (dec) begin
            addr = page_w + start_w - prog_w - ADDRW'(1);
        end else begin
            addr = page_w + start_w + prog_w;
        end
        last = (prog + PROGW'(1)) >= len_w;
    end

endmodule

// File: rtl/dma_svc_chan_state.sv
module dma_svc_chan_state #(
    parameter int NCTRL  = 2,
    parameter int CH_PER = 4,
    parameter int PROGW  = 18,
    localparam int NCH   = NCTRL * CH_PER,
    localparam int CHW   = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     dreq_hold,
    input  logic [NCH-1:0]     dreq_release,
    input  logic               sw_we,
    input  logic [CHW-1:0]     sw_ch,
    input  logic               sw_set,
    input  logic [NCH-1:0]     chan_init,
    input  logic [NCTRL-1:0]   tc_clr,
    input  logic               beat_ok,
    input  logic [CHW-1:0]     beat_ch,
    input  logic               beat_last,
    output logic [NCH-1:0]     req,
    output logic [NCH-1:0]     tc,
    output logic [NCH*PROGW-1:0] prog
);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic             hit;
        logic             sw_hit;
        logic             set_r;
        logic             clr_r;
        logic [PROGW-1:0] prog_q;

        assign hit    = beat_ok && (beat_ch == CHW'(n));
        assign sw_hit = sw_we && (sw_ch == CHW'(n));
        assign set_r  = dreq_hold[n] || (sw_hit && sw_set);
        assign clr_r  = dreq_release[n] || (sw_hit && !sw_set) || (hit && beat_last);
        assign prog[n*PROGW +: PROGW] = prog_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req[n] <= 1'b0;
                tc[n]  <= 1'b0;
                prog_q <= '0;
            end else begin
                if (set_r) begin
                    req[n] <= 1'b1;
                end else if (clr_r) begin
                    req[n] <= 1'b0;
                end

                if (hit && beat_last) begin
                    tc[n] <= 1'b1;
                end else if (tc_clr[n / CH_PER]) begin
                    tc[n] <= 1'b0;
                end

                if (chan_init[n]) begin
                    prog_q <= '0;
                end else if (hit) begin
                    prog_q <= beat_last ? '0 : prog_q + PROGW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/dma_svc_engine.sv
module dma_svc_engine
    import dma_svc_pkg::*;
#(
    parameter int NCTRL  = 2,
    parameter int CH_PER = 4,
    parameter int CNTW   = 16,
    parameter int PAGEW  = 8,
    localparam int NCH   = NCTRL * CH_PER,
    localparam int CHW   = $clog2(NCH),
    localparam int CPW   = $clog2(CH_PER),
    localparam int CTW   = (NCTRL > 1) ? $clog2(NCTRL) : 1,
    localparam int PROGW = CNTW + NCTRL,
    localparam int ADDRW = PAGEW + CNTW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        mask_i,
    input  logic [NCTRL-1:0]      ctrl_disable_i,
    input  logic [NCH-1:0]        mode_dec_i,
    input  logic [NCH*PAGEW-1:0]  page_i,
    input  logic [NCH*CNTW-1:0]   base_addr_i,
    input  logic [NCH*CNTW-1:0]   base_cnt_i,
    input  logic [NCH-1:0]        chan_init_i,
    input  logic [NCH-1:0]        dreq_hold_i,
    input  logic [NCH-1:0]        dreq_release_i,
    input  logic                  sw_req_we_i,
    input  logic [CHW-1:0]        sw_req_ch_i,
    input  logic                  sw_req_set_i,
    input  logic [NCTRL-1:0]      tc_clr_i,
    input  logic [NCH-1:0]        dev_rdy_i,
    input  logic                  mem_rdy_i,
    output logic                  mem_req_o,
    output logic [ADDRW-1:0]      mem_addr_o,
    output logic [CHW-1:0]        mem_chan_o,
    output logic [NCH-1:0]        req_o,
    output logic [NCH-1:0]        tc_o
);

    svc_state_e         state_q;
    logic [CHW-1:0]     cur_q;
    logic [NCH-1:0]     req_w;
    logic [NCH-1:0]     tc_w;
    logic [NCH*PROGW-1:0] prog_w;
    logic [NCH-1:0]     elig;
    logic               found;
    logic [CHW-1:0]     pick;
    logic               beat_ok;
    logic               beat_last;
    logic [CHW-1:0]     ctrl_of;
    logic [CTW-1:0]     shift;
    logic [ADDRW-1:0]   addr_w;

    // Eligibility per channel; the controller index is the upper channel bits.
    for (genvar n = 0; n < NCH; n++) begin : g_elig
        assign elig[n] = req_w[n] && !mask_i[n] && dev_rdy_i[n]
                         && !ctrl_disable_i[n / CH_PER];
    end

    dma_svc_pick #(.N(NCH)) u_pick (
        .elig  (elig),
        .found (found),
        .idx   (pick)
    );

    dma_svc_chan_state #(
        .NCTRL  (NCTRL),
        .CH_PER (CH_PER),
        .PROGW  (PROGW)
    ) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .dreq_hold    (dreq_hold_i),
        .dreq_release (dreq_release_i),
        .sw_we        (sw_req_we_i),
        .sw_ch        (sw_req_ch_i),
        .sw_set       (sw_req_set_i),
        .chan_init    (chan_init_i),
        .tc_clr       (tc_clr_i),
        .beat_ok      (beat_ok),
        .beat_ch      (cur_q),
        .beat_last    (beat_last),
        .req          (req_w),
        .tc           (tc_w),
        .prog         (prog_w)
    );

    assign ctrl_of = cur_q >> CPW;
    assign shift   = ctrl_of[CTW-1:0];

    dma_svc_addr #(
        .CNTW  (CNTW),
        .PAGEW (PAGEW),
        .SHW   (CTW),
        .PROGW (PROGW)
    ) u_addr (
        .base_addr (base_addr_i[cur_q*CNTW +: CNTW]),
        .base_cnt  (base_cnt_i[cur_q*CNTW +: CNTW]),
        .page      (page_i[cur_q*PAGEW +: PAGEW]),
        .dec       (mode_dec_i[cur_q]),
        .shift     (shift),
        .prog      (prog_w[cur_q*PROGW +: PROGW]),
        .addr      (addr_w),
        .last      (beat_last)
    );

    // State register: pick / idle out of SCAN, accept / stall out of BEAT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            cur_q   <= '0;
        end else begin
            unique case (state_q)
                ST_SCAN: begin
                    if (found) begin
                        state_q <= ST_BEAT;
                        cur_q   <= pick;
                    end
                end
                ST_BEAT: begin
                    if (mem_rdy_i) begin
                        state_q <= ST_SCAN;
                    end
                end
                default: state_q <= ST_SCAN;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        mem_req_o  = 1'b0;
        beat_ok    = 1'b0;
        unique case (state_q)
            ST_SCAN: mem_req_o = 1'b0;
            ST_BEAT: begin
                mem_req_o = 1'b1;
                beat_ok   = mem_rdy_i;
            end
            default: mem_req_o = 1'b0;
        endcase
        mem_addr_o = addr_w;
        mem_chan_o = cur_q;
        req_o      = req_w;
        tc_o       = tc_w;
    end

endmodule

// File: rtl/dma_svc_engine_chk.sv
module dma_svc_engine_chk #(
    parameter int NCTRL  = 2,
    parameter int CH_PER = 4,
    localparam int NCH   = NCTRL * CH_PER,
    localparam int CHW   = $clog2(NCH),
    localparam int CPW   = $clog2(CH_PER)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   mask_i,
    input logic [NCTRL-1:0] ctrl_disable_i,
    input logic [NCH-1:0]   dev_rdy_i,
    input logic             mem_req_o,
    input logic             mem_rdy_i,
    input logic [CHW-1:0]   mem_chan_o,
    input logic [NCH-1:0]   req_o,
    input logic [NCH-1:0]   tc_o
);

    logic [NCH-1:0]   mask_q;
    logic [NCH-1:0]   req_q;
    logic [NCH-1:0]   dev_q;
    logic [NCTRL-1:0] dis_q;
    logic [NCH-1:0]   tc_q;
    logic             acc_q;
    logic [CHW-1:0]   ctl_ix;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            req_q  <= '0;
            dev_q  <= '0;
            dis_q  <= '1;
            tc_q   <= '0;
            acc_q  <= 1'b0;
        end else begin
            mask_q <= mask_i;
            req_q  <= req_o;
            dev_q  <= dev_rdy_i;
            dis_q  <= ctrl_disable_i;
            tc_q   <= tc_o;
            acc_q  <= mem_req_o && mem_rdy_i;
        end
    end

    assign ctl_ix = mem_chan_o >> CPW;

    // R1
    pick_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> (!mask_q[mem_chan_o] && req_q[mem_chan_o] && dev_q[mem_chan_o]));

    // R2
    ctrl_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> !dis_q[ctl_ix]);

    // R8
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_chan_o)));

    // R9
    rescan_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_rdy_i) |=> !mem_req_o);

    // R10
    tc_from_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tc_o & ~tc_q) != '0) |-> (acc_q && $onehot0(tc_o & ~tc_q)));

    // R13
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!mem_req_o && req_o == '0 && tc_o == '0));

endmodule

bind dma_svc_engine dma_svc_engine_chk #(
    .NCTRL  (NCTRL),
    .CH_PER (CH_PER)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mask_i         (mask_i),
    .ctrl_disable_i (ctrl_disable_i),
    .dev_rdy_i      (dev_rdy_i),
    .mem_req_o      (mem_req_o),
    .mem_rdy_i      (mem_rdy_i),
    .mem_chan_o     (mem_chan_o),
    .req_o          (req_o),
    .tc_o           (tc_o)
);

// File: tb/dma_svc_engine_tb.sv
module dma_svc_engine_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   mask_i = 8'hFF;
    logic [1:0]   ctrl_disable_i = 2'b00;
    logic [7:0]   mode_dec_i = 8'h00;
    logic [63:0]  page_i = '0;
    logic [127:0] base_addr_i = '0;
    logic [127:0] base_cnt_i = {8{16'h00FF}};
    logic [7:0]   chan_init_i = '0;
    logic [7:0]   dreq_hold_i = '0;
    logic [7:0]   dreq_release_i = '0;
    logic         sw_req_we_i = 1'b0;
    logic [2:0]   sw_req_ch_i = '0;
    logic         sw_req_set_i = 1'b0;
    logic [1:0]   tc_clr_i = '0;
    logic [7:0]   dev_rdy_i = 8'hFF;
    logic         mem_rdy_i = 1'b0;
    logic         mem_req_o;
    logic [23:0]  mem_addr_o;
    logic [2:0]   mem_chan_o;
    logic [7:0]   req_o;
    logic [7:0]   tc_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dma_svc_engine u_dut (
        .clk (clk), .rst_n (rst_n), .mask_i (mask_i), .ctrl_disable_i (ctrl_disable_i),
        .mode_dec_i (mode_dec_i), .page_i (page_i), .base_addr_i (base_addr_i),
        .base_cnt_i (base_cnt_i), .chan_init_i (chan_init_i), .dreq_hold_i (dreq_hold_i),
        .dreq_release_i (dreq_release_i), .sw_req_we_i (sw_req_we_i),
        .sw_req_ch_i (sw_req_ch_i), .sw_req_set_i (sw_req_set_i), .tc_clr_i (tc_clr_i),
        .dev_rdy_i (dev_rdy_i), .mem_rdy_i (mem_rdy_i), .mem_req_o (mem_req_o),
        .mem_addr_o (mem_addr_o), .mem_chan_o (mem_chan_o), .req_o (req_o), .tc_o (tc_o)
    );

    // Block vectors: channel, base, count, page, direction, expected beats/first/last.
    localparam int NV = 5;
    localparam logic [2:0]  V_CH   [NV] = '{3'd0, 3'd2, 3'd5, 3'd7, 3'd1};
    localparam logic [15:0] V_BASE [NV] = '{16'h1000, 16'h0010, 16'h0800, 16'h0004, 16'hFFFE};
    localparam logic [15:0] V_CNT  [NV] = '{16'd3, 16'd2, 16'd1, 16'd0, 16'd2};
    localparam logic [7:0]  V_PAGE [NV] = '{8'h12, 8'h05, 8'h20, 8'h33, 8'h01};
    localparam logic        V_DEC  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam int          V_LEN  [NV] = '{4, 3, 4, 2, 3};
    localparam logic [23:0] V_FIRST[NV] = '{24'h121000, 24'h05000F, 24'h201000, 24'h330007, 24'h01FFFE};
    localparam logic [23:0] V_LAST [NV] = '{24'h121003, 24'h05000D, 24'h201003, 24'h330006, 24'h020000};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic accept_one();
        mem_rdy_i = 1'b1;
        step(1);
        mem_rdy_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog R8 actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int beats;
        logic [23:0] first_a, last_a;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R13 req after reset", 32'(req_o), 0);
        chk("R13 tc after reset", 32'(tc_o), 0);
        chk("R13 mem_req after reset", 32'(mem_req_o), 0);

        // Table walk: full blocks with memory always ready.
        for (int v = 0; v < NV; v++) begin
            base_addr_i[V_CH[v]*16 +: 16] = V_BASE[v];
            base_cnt_i[V_CH[v]*16 +: 16]  = V_CNT[v];
            page_i[V_CH[v]*8 +: 8]        = V_PAGE[v];
            mode_dec_i[V_CH[v]]           = V_DEC[v];
            mask_i      = ~(8'b1 << V_CH[v]);
            mem_rdy_i   = 1'b1;
            chan_init_i = 8'b1 << V_CH[v];
            step(1);
            chan_init_i = '0;
            dreq_hold_i = 8'b1 << V_CH[v];
            step(1);
            dreq_hold_i = '0;
            beats = 0;
            first_a = '0;
            last_a = '0;
            for (int c = 0; c < 100; c++) begin
                if (mem_req_o && mem_rdy_i) begin
                    if (beats == 0) first_a = mem_addr_o;
                    last_a = mem_addr_o;
                    beats++;
                    chk("R3 beat channel", 32'(mem_chan_o), 32'(V_CH[v]));
                end
                if (tc_o[V_CH[v]]) break;
                step(1);
            end
            mem_rdy_i = 1'b0;
            chk("R5 beat count", 32'(beats), 32'(V_LEN[v]));
            chk(V_DEC[v] ? "R7 first address" : "R6 first address", 32'(first_a), 32'(V_FIRST[v]));
            chk(V_DEC[v] ? "R7 last address" : "R6 last address", 32'(last_a), 32'(V_LAST[v]));
            chk("R10 tc set", 32'(tc_o[V_CH[v]]), 1);
            chk("R10 request cleared", 32'(req_o[V_CH[v]]), 0);
            tc_clr_i = 2'b1 << (1 - V_CH[v][2]);
            step(1);
            tc_clr_i = '0;
            chk("R11 other controller clear ignored", 32'(tc_o[V_CH[v]]), 1);
            tc_clr_i = 2'b1 << V_CH[v][2];
            step(1);
            tc_clr_i = '0;
            chk("R11 tc cleared", 32'(tc_o[V_CH[v]]), 0);
        end

        // R1 / R14: masked request waits, then runs on unmask.
        mask_i = 8'hFF;
        dreq_hold_i = 8'h08;
        step(1);
        dreq_hold_i = '0;
        step(4);
        chk("R1 masked not served", 32'(mem_req_o), 0);
        chk("R4 hold sets request", 32'(req_o[3]), 1);
        mask_i = 8'hF7;
        step(2);
        chk("R14 unmasked served", 32'(mem_req_o), 1);
        chk("R14 unmasked channel", 32'(mem_chan_o), 3);
        step(3);
        chk("R8 stall holds request", 32'(mem_req_o), 1);
        chk("R8 stall holds channel", 32'(mem_chan_o), 3);
        dreq_release_i = 8'h08;
        step(1);
        dreq_release_i = '0;
        chk("R4 release clears request", 32'(req_o[3]), 0);
        accept_one();
        chk("R9 gap after beat", 32'(mem_req_o), 0);
        step(2);
        chk("R4 released not served", 32'(mem_req_o), 0);

        // R3 / R9: priority across controllers and re-evaluation between beats.
        mask_i = 8'h00;
        dreq_hold_i = 8'h24;
        step(1);
        dreq_hold_i = '0;
        step(2);
        chk("R3 controller 0 first", 32'(mem_chan_o), 2);
        dreq_hold_i = 8'h01;
        step(1);
        dreq_hold_i = '0;
        accept_one();
        step(1);
        chk("R9 new higher request next", 32'(mem_chan_o), 0);
        chk("R9 beat offered", 32'(mem_req_o), 1);
        dreq_release_i = 8'h05;
        step(1);
        dreq_release_i = '0;
        accept_one();
        step(1);
        chk("R3 controller 1 after", 32'(mem_chan_o), 5);

        // R2: disabled controller skipped, resumes when enabled.
        ctrl_disable_i = 2'b10;
        accept_one();
        step(3);
        chk("R2 disabled controller idle", 32'(mem_req_o), 0);
        chk("R2 request kept", 32'(req_o[5]), 1);
        ctrl_disable_i = 2'b00;
        step(2);
        chk("R14 enable resumes", 32'(mem_chan_o), 5);
        chk("R14 enable beat", 32'(mem_req_o), 1);
        dreq_release_i = 8'h20;
        step(1);
        dreq_release_i = '0;
        accept_one();

        // R1: device not ready.
        dev_rdy_i = 8'hBF;
        dreq_hold_i = 8'h40;
        step(1);
        dreq_hold_i = '0;
        step(3);
        chk("R1 device not ready idle", 32'(mem_req_o), 0);
        dev_rdy_i = 8'hFF;
        step(2);
        chk("R1 device ready served", 32'(mem_chan_o), 6);
        dreq_release_i = 8'h40;
        step(1);
        dreq_release_i = '0;
        accept_one();

        // R4: software request writes and set-wins.
        mask_i = 8'hFF;
        sw_req_we_i = 1'b1;
        sw_req_ch_i = 3'd1;
        sw_req_set_i = 1'b1;
        step(1);
        sw_req_we_i = 1'b0;
        chk("R4 software set", 32'(req_o[1]), 1);
        sw_req_we_i = 1'b1;
        sw_req_set_i = 1'b0;
        step(1);
        sw_req_we_i = 1'b0;
        chk("R4 software clear", 32'(req_o[1]), 0);
        dreq_hold_i = 8'h02;
        dreq_release_i = 8'h02;
        step(1);
        dreq_hold_i = '0;
        dreq_release_i = '0;
        chk("R4 set wins", 32'(req_o[1]), 1);
        dreq_release_i = 8'h02;
        step(1);
        dreq_release_i = '0;

        // R8 / R12: progress advance and re-init.
        base_addr_i[0 +: 16] = 16'h0100;
        base_cnt_i[0 +: 16]  = 16'd9;
        page_i[0 +: 8]       = 8'h00;
        mode_dec_i[0]        = 1'b0;
        chan_init_i = 8'h01;
        step(1);
        chan_init_i = '0;
        mask_i = 8'hFE;
        dreq_hold_i = 8'h01;
        step(1);
        dreq_hold_i = '0;
        step(1);
        chk("R6 first beat address", 32'(mem_addr_o), 32'h000100);
        accept_one();
        step(1);
        chk("R8 progress advanced", 32'(mem_addr_o), 32'h000101);
        chan_init_i = 8'h01;
        step(1);
        chan_init_i = '0;
        chk("R12 init restarts address", 32'(mem_addr_o), 32'h000100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule